// File: doc/BRIEF.md
# Shared RAM Host Port with Reset Write Lockout

This block gives a host bus access to a small RAM array that a second agent (for example a timer coprocessor) reads through its own read-only port. The host issues byte, halfword and 32-bit accesses. A 32-bit access is carried out internally as two back-to-back 16-bit cycles. The upper half goes first, to the even halfword. The array is held in internal registers and is cleared only by the power-on reset `rstN`.

A second, synchronous reset input `syncRst` models a system reset that must not corrupt the array. Any write cycle already under way is allowed to finish. New writes are refused for as long as `syncRst` stays high. Because a 32-bit write is two cycles, a reset that lands in the first one leaves the word with a new upper half and an old lower half.

A one-bit control register holds a stop flag. While the flag is set, the array is sealed: host accesses to it are refused, its contents are kept, and the coprocessor read port holds its last value. The control register itself stays reachable, so the host can clear the flag.

Top module: `rbi_top`

## Requirements
- R1: The size code `busSize` is 00 for byte, 01 for halfword and 10 for a 32-bit word; 11 is treated as halfword. Data is right-aligned in `busWData`/`busRData` and zero-extended. In a byte access, `busAddr` bit 0 = 0 selects bits [15:8] of the halfword and 1 selects bits [7:0]. A request sampled while idle is acknowledged by a one-cycle `busAck` in the second cycle after it is accepted. Read data is valid in that same cycle.
- R2: A 32-bit access uses halfword indices `{busAddr[AW-1:2],0}` for the upper half and `{busAddr[AW-1:2],1}` for the lower half, in that order. Its acknowledge comes four cycles after acceptance. A 32-bit read returns `{upper,lower}`.
- R3: If `syncRst` rises after a byte or halfword write has been accepted, that write still updates the array and is acknowledged with `busErr` low.
- R4: A write to the array accepted while `syncRst` is high leaves the array unchanged and is acknowledged with `busErr` high. Reads of the array are still served during reset.
- R5: If `syncRst` is sampled high at any edge after a 32-bit write is accepted and up to the edge that commits its upper half, the upper half is stored and the lower half keeps its old value. The second cycle is dropped, and the access is acknowledged at the end of the first half with `busErr` low.
- R6: If `syncRst` rises only after the upper half of a 32-bit write has been committed, the lower half is still written and the word is coherent.
- R7: The control register is selected with `busReg` = 1. A read returns the stop flag in bit 0 and zeros elsewhere; a write loads the flag from `busWData[0]`. Register accesses never raise `busErr`. The flag is 0 after power-on reset and is cleared on every edge at which `syncRst` is high. Register writes made while `syncRst` is high are ignored.
- R8: While the stop flag is set, every host array access (read or write) is acknowledged with `busErr` high and zero read data, and no array location changes.
- R9: While the stop flag is set, the control register can still be read and written. Clearing the flag restores array access with the contents unchanged.
- R10: `cpData` shows the array halfword at `cpAddr` one clock edge later. It holds its value while the stop flag is set.
- R11: During and after power-on reset, `busAck`, `busErr`, `busRData` and `cpData` are zero, and the array reads back zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low; clears all state including the array |
| syncRst | input | 1 | Synchronous system reset, active high; blocks new writes and clears the stop flag |
| busReq | input | 1 | Host request strobe, sampled only while the port is idle |
| busWr | input | 1 | 1 = write, 0 = read |
| busReg | input | 1 | 1 = control register, 0 = array |
| busSize | input | 2 | Access size code (R1) |
| busAddr | input | AW | Byte address into the array |
| busWData | input | 32 | Write data, right-aligned |
| busAck | output | 1 | One-cycle access completion |
| busErr | output | 1 | Refused access, valid with `busAck` |
| busRData | output | 32 | Read data, valid with `busAck` |
| cpAddr | input | AW-1 | Coprocessor halfword index |
| cpData | output | 16 | Coprocessor read data, registered |

## Verification
The assertions assume a host that raises `busReq` only while no access is outstanding and waits for `busAck` before the next request. They also assume that 32-bit accesses are word-aligned, and that the stop flag is changed only by register writes, never alongside an array access. The stimulus issues one access at a time through a single driver task and keeps all word accesses on multiples of four. It raises `syncRst` only at falling edges counted from the request, so each reset lands in a known phase of the cycle under test.

// File: rtl/rbi_pkg.sv
package rbi_pkg;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  // Which slice of the latched host data goes to the array, and how the
  // current halfword is formatted on the read path.
  typedef enum logic [1:0] {
    FMT_BYTE,
    FMT_HALF,
    FMT_WHI,
    FMT_WLO
  } fmt_e;

  // Control to datapath strobes.
  typedef struct packed {
    logic       capReq;     // latch host write data
    logic       arrWr;      // commit to array this cycle
    logic       capUpper;   // hold upper half of a word read
    logic       respValid;  // response cycle
    logic       respZero;   // force zero read data
    logic       respReg;    // response comes from control register
    logic [1:0] lane;       // byte lanes {hi,lo}
    fmt_e       fmt;
  } strobe_t;

endpackage

// File: rtl/rbi_ctrl.sv
module rbi_ctrl
  import rbi_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          syncRst,
  input  logic          busReq,
  input  logic          busWr,
  input  logic          busReg,
  input  logic [1:0]    busSize,
  input  logic [AW-1:0] busAddr,
  input  logic          busWBit0,
  output logic          busAck,
  output logic          busErr,
  output logic          stopQ,
  output logic [AW-2:0] arrIdx,
  output strobe_t       stb
);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} st_e;

  st_e           state;
  logic          qWr;
  logic          qReg;
  logic [1:0]    qSize;
  logic [AW-1:0] qAddr;
  logic          qBit0;
  logic          qBlk;
  logic          half;
  logic          rstSeen;

  logic isWord;
  logic splitCyc;
  logic lastHalf;
  logic inData;
  logic regWr;
  logic blkNow;

  assign isWord   = (qSize == SZ_WORD);
  assign splitCyc = isWord && !qReg && !qBlk;
  assign inData   = (state == ST_DATA);
  // A write ends early when reset has been seen during its first half.
  assign lastHalf = !splitCyc || half || (qWr && (rstSeen || syncRst));
  assign regWr    = inData && qWr && qReg;
  assign blkNow   = !busReg && ((busWr && syncRst) || stopQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      qWr     <= 1'b0;
      qReg    <= 1'b0;
      qSize   <= SZ_BYTE;
      qAddr   <= '0;
      qBit0   <= 1'b0;
      qBlk    <= 1'b0;
      half    <= 1'b0;
      rstSeen <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (busReq) begin
            state   <= ST_ADDR;
            qWr     <= busWr;
            qReg    <= busReg;
            qSize   <= busSize;
            qAddr   <= busAddr;
            qBit0   <= busWBit0;
            qBlk    <= blkNow;
            half    <= 1'b0;
            rstSeen <= 1'b0;
          end
        end
        ST_ADDR: begin
          state   <= ST_DATA;
          rstSeen <= rstSeen | syncRst;
        end
        ST_DATA: begin
          if (lastHalf) begin
            state <= ST_IDLE;
          end else begin
            state <= ST_ADDR;
            half  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        stopQ <= 1'b0;
    else if (syncRst) stopQ <= 1'b0;
    else if (regWr)   stopQ <= qBit0;
  end

  assign busAck = inData && lastHalf;
  assign busErr = busAck && qBlk;

  always_comb begin
    if (isWord && !qReg) arrIdx = {qAddr[AW-1:2], half};
    else                 arrIdx = qAddr[AW-1:1];
  end

  always_comb begin
    stb           = '0;
    stb.capReq    = (state == ST_IDLE) && busReq;
    stb.arrWr     = inData && qWr && !qReg && !qBlk;
    stb.capUpper  = inData && splitCyc && !half;
    stb.respValid = busAck;
    stb.respZero  = qBlk || qWr;
    stb.respReg   = qReg;
    if (qSize == SZ_BYTE) stb.lane = qAddr[0] ? 2'b01 : 2'b10;
    else                  stb.lane = 2'b11;
    if (qSize == SZ_BYTE)     stb.fmt = FMT_BYTE;
    else if (isWord && !qReg) stb.fmt = half ? FMT_WLO : FMT_WHI;
    else                      stb.fmt = FMT_HALF;
  end

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    busAck |=> !busAck);  // R1

  AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> busAck);  // R4

  AST_STOP_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    syncRst |=> !stopQ);  // R7

  AST_SPLIT_NEEDS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && half && qWr) |-> !$past(syncRst));  // R5

endmodule

// File: rtl/rbi_datapath.sv
module rbi_datapath
  import rbi_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IW    = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [IW-1:0] arrIdx,
  input  logic [31:0]   busWData,
  input  logic          stopIn,
  input  logic [IW-1:0] cpAddr,
  output logic [31:0]   busRData,
  output logic [15:0]   cpData
);

  logic [15:0] mem [DEPTH];
  logic [31:0] wq;
  logic [15:0] upperHold;
  logic [15:0] wrHalf;
  logic [15:0] cur;

  assign cur = mem[arrIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           wq <= '0;
    else if (stb.capReq) wq <= busWData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             upperHold <= '0;
    else if (stb.capUpper) upperHold <= cur;
  end

  always_comb begin
    case (stb.fmt)
      FMT_BYTE: wrHalf = {wq[7:0], wq[7:0]};
      FMT_WHI:  wrHalf = wq[31:16];
      default:  wrHalf = wq[15:0];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (stb.arrWr) begin
      if (stb.lane[1]) mem[arrIdx][15:8] <= wrHalf[15:8];
      if (stb.lane[0]) mem[arrIdx][7:0]  <= wrHalf[7:0];
    end
  end

  always_comb begin
    busRData = '0;
    if (stb.respValid && !stb.respZero) begin
      if (stb.respReg) begin
        busRData = {31'd0, stopIn};
      end else begin
        case (stb.fmt)
          FMT_BYTE: busRData = {24'd0, stb.lane[1] ? cur[15:8] : cur[7:0]};
          FMT_WLO:  busRData = {upperHold, cur};
          default:  busRData = {16'd0, cur};
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cpData <= '0;
    else if (!stopIn) cpData <= mem[cpAddr];
  end

  AST_NO_ARRAY_WRITE_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    stb.arrWr |-> !stopIn);  // R8

  AST_CP_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    stopIn |=> $stable(cpData));  // R10

  AST_ZERO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !stb.respValid |-> (busRData == 32'd0));  // R1

endmodule

// File: rtl/rbi_top.sv
module rbi_top
  import rbi_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int IW    = $clog2(DEPTH),
  localparam int AW    = IW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          syncRst,
  input  logic          busReq,
  input  logic          busWr,
  input  logic          busReg,
  input  logic [1:0]    busSize,
  input  logic [AW-1:0] busAddr,
  input  logic [31:0]   busWData,
  output logic          busAck,
  output logic          busErr,
  output logic [31:0]   busRData,
  input  logic [IW-1:0] cpAddr,
  output logic [15:0]   cpData
);

  strobe_t       stb;
  logic          stopQ;
  logic [IW-1:0] arrIdx;

  rbi_ctrl #(.AW(AW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .syncRst  (syncRst),
    .busReq   (busReq),
    .busWr    (busWr),
    .busReg   (busReg),
    .busSize  (busSize),
    .busAddr  (busAddr),
    .busWBit0 (busWData[0]),
    .busAck   (busAck),
    .busErr   (busErr),
    .stopQ    (stopQ),
    .arrIdx   (arrIdx),
    .stb      (stb)
  );

  rbi_datapath #(.DEPTH(DEPTH), .IW(IW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .arrIdx   (arrIdx),
    .busWData (busWData),
    .stopIn   (stopQ),
    .cpAddr   (cpAddr),
    .busRData (busRData),
    .cpData   (cpData)
  );

endmodule

// File: tb/rbi_top_tb.sv
module rbi_top_tb;

  localparam int DEPTH = 64;
  localparam int IW    = $clog2(DEPTH);
  localparam int AW    = IW + 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          syncRst = 1'b0;
  logic          busReq = 1'b0;
  logic          busWr = 1'b0;
  logic          busReg = 1'b0;
  logic [1:0]    busSize = 2'b01;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busWData = '0;
  logic          busAck;
  logic          busErr;
  logic [31:0]   busRData;
  logic [IW-1:0] cpAddr = '0;
  logic [15:0]   cpData;

  rbi_top #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .syncRst(syncRst), .busReq(busReq),
    .busWr(busWr), .busReg(busReg), .busSize(busSize), .busAddr(busAddr),
    .busWData(busWData), .busAck(busAck), .busErr(busErr),
    .busRData(busRData), .cpAddr(cpAddr), .cpData(cpData)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } exp_t;

  exp_t q[$];
  int nChk = 0;
  int nBad = 0;
  int ackCount = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    nChk++;
    if (act !== expv) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard on every acknowledge.
  always @(negedge clk) begin
    #2;
    if (rstN && busAck) begin
      ackCount++;
      if (q.size() == 0) begin
        nChk++;
        nBad++;
        $display("FAIL R1 unexpected ack actual=1 expected=0");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " data"}, busRData, e.data);
        chk({e.tag, " err"}, {31'd0, busErr}, {31'd0, e.err});
      end
    end
  end

  // Driver: pushes the expectation, issues one access, optionally raises
  // syncRst at the rstAt-th falling edge after the request.
  task automatic acc(input logic rg, input logic wr, input logic [1:0] sz,
                     input logic [AW-1:0] a, input logic [31:0] wd, input int rstAt,
                     input logic [31:0] expD, input logic expE, input string tag);
    int startAcks;
    int k;
    q.push_back('{expD, expE, tag});
    startAcks = ackCount;
    @(negedge clk);
    busReq = 1'b1; busWr = wr; busReg = rg; busSize = sz; busAddr = a; busWData = wd;
    k = 0;
    while (ackCount == startAcks) begin
      @(negedge clk);
      busReq = 1'b0;
      k++;
      if (k == rstAt) syncRst = 1'b1;
      #3;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  logic [15:0] frozen;

  initial begin
    ticks(3);
    // R11 reset state
    chk("R11 ack", {31'd0, busAck}, 32'd0);
    chk("R11 err", {31'd0, busErr}, 32'd0);
    chk("R11 rdata", busRData, 32'd0);
    rstN = 1'b1;
    ticks(2);
    chk("R11 cpData", {16'd0, cpData}, 32'd0);
    acc(1, 0, 2'b01, 0, 0, -1, 32'd0, 0, "R11 stop reset value");
    acc(0, 0, 2'b01, 7'h30, 0, -1, 32'd0, 0, "R11 array zero");

    // R1 halfword and byte lanes
    acc(0, 1, 2'b01, 7'h04, 32'h1234, -1, 32'd0, 0, "R1 half write");
    acc(0, 0, 2'b01, 7'h04, 0, -1, 32'h1234, 0, "R1 half read");
    acc(0, 1, 2'b00, 7'h04, 32'hAB, -1, 32'd0, 0, "R1 byte write hi");
    acc(0, 1, 2'b00, 7'h05, 32'hCD, -1, 32'd0, 0, "R1 byte write lo");
    acc(0, 0, 2'b00, 7'h05, 0, -1, 32'hCD, 0, "R1 byte read lo");
    acc(0, 0, 2'b00, 7'h04, 0, -1, 32'hAB, 0, "R1 byte read hi");
    acc(0, 0, 2'b01, 7'h04, 0, -1, 32'hABCD, 0, "R1 merged half");

    // R2 word split
    acc(0, 1, 2'b10, 7'h08, 32'hDEADBEEF, -1, 32'd0, 0, "R2 word write");
    acc(0, 0, 2'b01, 7'h08, 0, -1, 32'hDEAD, 0, "R2 upper half");
    acc(0, 0, 2'b01, 7'h0A, 0, -1, 32'hBEEF, 0, "R2 lower half");
    acc(0, 0, 2'b10, 7'h08, 0, -1, 32'hDEADBEEF, 0, "R2 word read");

    // R10 coprocessor port
    cpAddr = 5;
    ticks(2);
    #2;
    chk("R10 cp read", {16'd0, cpData}, 32'h0000BEEF);

    // R3 reset during byte write; R4 blocked writes and live reads
    acc(0, 1, 2'b00, 7'h10, 32'h5A, 1, 32'd0, 0, "R3 byte write finishes");
    acc(0, 1, 2'b01, 7'h12, 32'h7777, -1, 32'd0, 1, "R4 write refused");
    acc(0, 0, 2'b01, 7'h10, 0, -1, 32'h5A00, 0, "R3 byte stored");
    acc(1, 1, 2'b01, 0, 32'h1, -1, 32'd0, 0, "R7 reg write in reset");
    acc(1, 0, 2'b01, 0, 0, -1, 32'd0, 0, "R7 reg write ignored");
    syncRst = 1'b0;
    ticks(1);
    acc(0, 0, 2'b01, 7'h12, 0, -1, 32'd0, 0, "R4 array unchanged");

    // R5 reset in first half of a word write
    acc(0, 1, 2'b10, 7'h20, 32'hAAAABBBB, -1, 32'd0, 0, "R5 preset");
    acc(0, 1, 2'b10, 7'h20, 32'hCCCCDDDD, 1, 32'd0, 0, "R5 truncated ack");
    ticks(2);
    syncRst = 1'b0;
    ticks(1);
    acc(0, 0, 2'b01, 7'h20, 0, -1, 32'hCCCC, 0, "R5 new upper");
    acc(0, 0, 2'b01, 7'h22, 0, -1, 32'hBBBB, 0, "R5 old lower");

    // R6 reset in second half
    acc(0, 1, 2'b10, 7'h28, 32'h01020304, -1, 32'd0, 0, "R6 preset");
    acc(0, 1, 2'b10, 7'h28, 32'h0A0B0C0D, 3, 32'd0, 0, "R6 full ack");
    ticks(1);
    syncRst = 1'b0;
    ticks(1);
    acc(0, 0, 2'b10, 7'h28, 0, -1, 32'h0A0B0C0D, 0, "R6 coherent");

    // R8 / R9 stop mode
    acc(1, 1, 2'b01, 0, 32'h1, -1, 32'd0, 0, "R9 set stop");
    acc(1, 0, 2'b01, 0, 0, -1, 32'd1, 0, "R9 stop readable");
    frozen = cpData;
    cpAddr = 4;
    ticks(3);
    #2;
    chk("R10 cp frozen", {16'd0, cpData}, {16'd0, frozen});
    acc(0, 0, 2'b10, 7'h08, 0, -1, 32'd0, 1, "R8 read refused");
    acc(0, 1, 2'b01, 7'h08, 32'h9999, -1, 32'd0, 1, "R8 write refused");
    acc(1, 1, 2'b01, 0, 32'h0, -1, 32'd0, 0, "R9 clear stop");
    acc(0, 0, 2'b01, 7'h08, 0, -1, 32'hDEAD, 0, "R8 contents kept");
    ticks(2);
    #2;
    chk("R10 cp resumes", {16'd0, cpData}, 32'h0000DEAD);

    // R7 stop cleared by syncRst
    acc(1, 1, 2'b01, 0, 32'h1, -1, 32'd0, 0, "R7 set stop");
    @(negedge clk);
    syncRst = 1'b1;
    ticks(2);
    syncRst = 1'b0;
    acc(1, 0, 2'b01, 0, 0, -1, 32'd0, 0, "R7 reset clears stop");
    acc(0, 0, 2'b01, 7'h0A, 0, -1, 32'hBEEF, 0, "R7 array usable");

    ticks(2);
    summary();
    $finish;
  end

endmodule